// File: doc/BRIEF.md
# Nibble Arithmetic and Logic Unit with Decimal Adjust

This block is the data path core of a small 4-bit processor. On every cycle it combines an accumulator nibble with an operand nibble (taken from data memory or from an instruction immediate) under a 4-bit operation code. It also uses the stored carry. Its outputs are a result nibble, the carry value that the operation would leave behind, and a flag that is high when the result is zero. The instruction sequencer uses that flag for its branch-if-zero and branch-if-not-zero decisions.

The result logic is purely combinational. The only state is a one-bit carry register. It captures the next-carry value at a rising clock edge whenever the sequencer raises `exec` to commit an instruction. One adder serves every arithmetic operation. Subtraction is performed by adding the complement of the operand, so a carry of 1 after a subtraction means that no borrow occurred. Decimal adjust reuses the same adder to add six when the accumulator is out of decimal range or when the carry is already set.

Top module: `nibble_alu`

## Requirements
- R1: ADD (opcode 0) gives the low nibble of acc+opd, and ADC (opcode 1) gives the low nibble of acc+opd+carry. In both cases carry_next is the carry out of bit 3.
- R2: SUB (opcode 2) computes acc+~opd+1, and SBC (opcode 3) computes acc+~opd+carry. carry_next is the carry out of bit 3, which is 1 when no borrow occurs and 0 on a borrow.
- R3: DAA (opcode 4) applies when acc>9 or carry=1. In that case the result is acc+6 modulo 16 and carry_next is 1. Otherwise the result equals acc and carry_next equals carry.
- R4: AND (opcode 5), OR (opcode 6) and XOR (opcode 7) give the bitwise result of acc and opd, and carry_next equals carry.
- R5: INC (opcode 8) gives acc+1 modulo 16 and DEC (opcode 9) gives acc-1 modulo 16. Both leave carry_next equal to carry.
- R6: RL (opcode 10) copies bit 3 into both result bit 0 and carry_next, while the other bits move up by one place. RR (opcode 12) copies bit 0 into both result bit 3 and carry_next, while the other bits move down by one place.
- R7: RLC (opcode 11) shifts left with the old carry entering bit 0 and bit 3 leaving into carry_next. RRC (opcode 13) shifts right with the old carry entering bit 3 and bit 0 leaving into carry_next.
- R8: SETC (opcode 14) drives carry_next to 1 and CLRC (opcode 15) drives carry_next to 0. Both pass acc through unchanged as the result.
- R9: zero is 1 exactly when the result nibble equals 0, for every opcode.
- R10: carry_q is 0 after reset. It takes the value of carry_next at a rising clock edge while exec is 1, and it holds its value while exec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the carry register |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Commits carry_next into the carry register at the next edge |
| op | input | 4 | Operation code (values listed in the requirements) |
| acc_in | input | 4 | Accumulator nibble |
| opd_in | input | 4 | Operand nibble from memory or an immediate |
| result | output | 4 | Result nibble |
| carry_next | output | 1 | Carry value the operation produces |
| carry_q | output | 1 | Stored carry flag |
| zero | output | 1 | High when result is zero |

## Verification
The cases that are hardest to reach depend on the stored carry rather than on the input pins. Examples are ADC, SBC and the through-carry rotates with carry set, and DAA with an in-range accumulator but carry already set. The carry can only be set by a committed earlier operation. For this reason the stimulus sweeps every opcode and operand pair and alternates exec, so that carry arrives at each operation both set and clear. Directed sequences use SETC and CLRC to fix the carry before each corner case. Sequences with exec held low show that the flag is untouched.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBC  = 4'd3,
      OP_DAA  = 4'd4,
      OP_AND  = 4'd5,
      OP_OR   = 4'd6,
      OP_XOR  = 4'd7,
      OP_INC  = 4'd8,
      OP_DEC  = 4'd9,
      OP_RL   = 4'd10,
      OP_RLC  = 4'd11,
      OP_RR   = 4'd12,
      OP_RRC  = 4'd13,
      OP_SETC = 4'd14,
      OP_CLRC = 4'd15
   } alu_op_e;
endpackage

// File: rtl/nib_adder.sv
module nib_adder #(
   parameter int W     = 4,
   parameter int STYLE = 0   // 0: inferred adder, 1: explicit ripple chain
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("nib_adder: STYLE must be 0 or 1");
      end
      if (STYLE == 0) begin : g_inferred
         logic [W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         assign sum  = wide[W-1:0];
         assign cout = wide[W];
      end else begin : g_ripple
         logic [W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ c[i];
            assign c[i+1]  = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
         end
         assign cout = c[W];
      end
   endgenerate
endmodule

// File: rtl/nib_bitops.sv
module nib_bitops
   import nib_alu_pkg::*;
#(
   parameter int W = 4
) (
   input  alu_op_e      opc,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] y,
   output logic         cout
);
   localparam int MSB = W - 1;

   logic [W-1:0] rot_l, rot_r;
   assign rot_l = {a[MSB-1:0], a[MSB]};
   assign rot_r = {a[0], a[MSB:1]};

   always_comb begin
      y    = a;
      cout = cin;
      unique case (opc)
         OP_AND: y = a & b;
         OP_OR:  y = a | b;
         OP_XOR: y = a ^ b;
         OP_RL: begin
            y    = rot_l;
            cout = a[MSB];
         end
         OP_RLC: begin
            y    = {a[MSB-1:0], cin};
            cout = a[MSB];
         end
         OP_RR: begin
            y    = rot_r;
            cout = a[0];
         end
         OP_RRC: begin
            y    = {cin, a[MSB:1]};
            cout = a[0];
         end
         default: begin
            y    = a;
            cout = cin;
         end
      endcase
   end
endmodule

// File: rtl/nib_carry_flag.sv
module nib_carry_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= 1'b0;
      else if (load) q <= d;
   end
endmodule

// File: rtl/nibble_alu.sv
module nibble_alu
   import nib_alu_pkg::*;
#(
   parameter int W           = 4,
   parameter int ADDER_STYLE = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            exec,
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    acc_in,
   input  logic [W-1:0]    opd_in,
   output logic [W-1:0]    result,
   output logic            carry_next,
   output logic            carry_q,
   output logic            zero
);
   localparam logic [W-1:0] BCD_FIX = W'(6);
   localparam logic [W-1:0] BCD_MAX = W'(9);
   localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

   generate
      if (W != 4) begin : g_bad_width
         $error("nibble_alu: decimal adjust is defined for W == 4 only");
      end
   endgenerate

   alu_op_e opc;
   assign opc = alu_op_e'(op);

   // shared adder operand selection
   logic [W-1:0] add_b, add_sum;
   logic         add_cin, add_cout;
   logic         daa_need;

   assign daa_need = (acc_in > BCD_MAX) || carry_q;

   always_comb begin
      add_b   = '0;
      add_cin = 1'b0;
      unique case (opc)
         OP_ADD: add_b = opd_in;
         OP_ADC: begin add_b = opd_in;  add_cin = carry_q; end
         OP_SUB: begin add_b = ~opd_in; add_cin = 1'b1;    end
         OP_SBC: begin add_b = ~opd_in; add_cin = carry_q; end
         OP_DAA: add_b = BCD_FIX;
         OP_INC: add_cin = 1'b1;
         OP_DEC: add_b = ALL_ONE;
         default: begin add_b = '0; add_cin = 1'b0; end
      endcase
   end

   nib_adder #(.W(W), .STYLE(ADDER_STYLE)) u_adder (
      .a    (acc_in),
      .b    (add_b),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout)
   );

   logic [W-1:0] bit_y;
   logic         bit_c;

   nib_bitops #(.W(W)) u_bitops (
      .opc  (opc),
      .a    (acc_in),
      .b    (opd_in),
      .cin  (carry_q),
      .y    (bit_y),
      .cout (bit_c)
   );

   // result and carry steering
   always_comb begin
      result     = acc_in;
      carry_next = carry_q;
      unique case (opc)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
            result     = add_sum;
            carry_next = add_cout;
         end
         OP_DAA: begin
            result     = daa_need ? add_sum : acc_in;
            carry_next = daa_need ? 1'b1 : carry_q;
         end
         OP_INC, OP_DEC: begin
            result     = add_sum;
            carry_next = carry_q;
         end
         OP_AND, OP_OR, OP_XOR, OP_RL, OP_RLC, OP_RR, OP_RRC: begin
            result     = bit_y;
            carry_next = bit_c;
         end
         OP_SETC: begin
            result     = acc_in;
            carry_next = 1'b1;
         end
         OP_CLRC: begin
            result     = acc_in;
            carry_next = 1'b0;
         end
         default: begin
            result     = acc_in;
            carry_next = carry_q;
         end
      endcase
   end

   assign zero = (result == '0);

   nib_carry_flag u_cflag (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (exec),
      .d     (carry_next),
      .q     (carry_q)
   );
endmodule

// File: rtl/nibble_alu_chk.sv
module nibble_alu_chk
   import nib_alu_pkg::*;
#(
   parameter int W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exec,
   input logic [OP_W-1:0] op,
   input logic [W-1:0]    acc_in,
   input logic [W-1:0]    opd_in,
   input logic [W-1:0]    result,
   input logic            carry_next,
   input logic            carry_q,
   input logic            zero
);
   p_add_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_ADD) |-> ({carry_next, result} == ({1'b0, acc_in} + {1'b0, opd_in})));

   p_sub_noborrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SUB) |-> (carry_next == (acc_in >= opd_in)));

   p_daa_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DAA && carry_q) |-> carry_next);

   p_logic_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_AND || op == OP_OR || op == OP_XOR) |-> (carry_next == carry_q));

   p_inc_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INC) |-> (result == (acc_in + 1'b1) && carry_next == carry_q));

   p_rl_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RL) |-> (carry_next == acc_in[W-1] && result[0] == acc_in[W-1]));

   p_rrc_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_RRC) |-> (result[W-1] == carry_q && carry_next == acc_in[0]));

   p_setc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SETC) |-> (carry_next && result == acc_in));

   p_zero_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SUB) |-> (zero == (acc_in == opd_in)));

   p_carry_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exec |=> (carry_q == $past(carry_next)));

   p_carry_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !exec |=> $stable(carry_q));
endmodule

bind nibble_alu nibble_alu_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .exec       (exec),
   .op         (op),
   .acc_in     (acc_in),
   .opd_in     (opd_in),
   .result     (result),
   .carry_next (carry_next),
   .carry_q    (carry_q),
   .zero       (zero)
);

// File: tb/tb_nibble_alu.sv
module tb_nibble_alu;
   localparam int CLK_PERIOD = 10;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         exec = 1'b0;
   logic [3:0]   op = 4'd0;
   logic [W-1:0] acc_in = '0;
   logic [W-1:0] opd_in = '0;
   logic [W-1:0] result;
   logic         carry_next;
   logic         carry_q;
   logic         zero;

   int n_checks = 0;
   int n_fails  = 0;
   bit model_c  = 1'b0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nibble_alu dut (
      .clk(clk), .rst_n(rst_n), .exec(exec), .op(op),
      .acc_in(acc_in), .opd_in(opd_in), .result(result),
      .carry_next(carry_next), .carry_q(carry_q), .zero(zero)
   );

   typedef struct {
      logic [3:0] op;
      logic [3:0] a;
      logic [3:0] b;
      logic [3:0] res;
      logic       cn;
      logic       cq;
      logic       z;
   } item_t;

   item_t exp_q[$];

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1:   return "R1";
         4'd2, 4'd3:   return "R2";
         4'd4:         return "R3";
         4'd5, 4'd6, 4'd7: return "R4";
         4'd8, 4'd9:   return "R5";
         4'd10, 4'd12: return "R6";
         4'd11, 4'd13: return "R7";
         default:      return "R8";
      endcase
   endfunction

   // independent reference model
   task automatic model(input logic [3:0] o, input logic [3:0] a, input logic [3:0] b,
                        input bit c, output logic [3:0] r, output logic cn);
      int s;
      r = a; cn = c;
      case (o)
         4'd0:  begin s = a + b;               r = s[3:0]; cn = s[4]; end
         4'd1:  begin s = a + b + c;           r = s[3:0]; cn = s[4]; end
         4'd2:  begin s = a + (15 - b) + 1;    r = s[3:0]; cn = s[4]; end
         4'd3:  begin s = a + (15 - b) + c;    r = s[3:0]; cn = s[4]; end
         4'd4:  if (a > 9 || c) begin s = a + 6; r = s[3:0]; cn = 1'b1; end
         4'd5:  r = a & b;
         4'd6:  r = a | b;
         4'd7:  r = a ^ b;
         4'd8:  r = a + 4'd1;
         4'd9:  r = a - 4'd1;
         4'd10: begin r = {a[2:0], a[3]}; cn = a[3]; end
         4'd11: begin r = {a[2:0], c};    cn = a[3]; end
         4'd12: begin r = {a[0], a[3:1]}; cn = a[0]; end
         4'd13: begin r = {c, a[3:1]};    cn = a[0]; end
         4'd14: cn = 1'b1;
         default: cn = 1'b0;
      endcase
   endtask

   // driver: applies one operation and pushes the expected item
   task automatic drive(input logic [3:0] o, input logic [3:0] a, input logic [3:0] b,
                        input bit ex);
      item_t it;
      logic [3:0] r;
      logic cn;
      @(negedge clk);
      op = o; acc_in = a; opd_in = b; exec = ex;
      model(o, a, b, model_c, r, cn);
      it.op = o; it.a = a; it.b = b; it.res = r; it.cn = cn;
      it.cq = model_c; it.z = (r == 4'd0);
      exp_q.push_back(it);
      if (ex) model_c = cn;
   endtask

   task automatic fail_line(input string req, input string what, input int got, input int expv,
                            input item_t it);
      n_fails++;
      $display("FAIL %s %s: op=%0d a=%h b=%h got %h expected %h",
               req, what, it.op, it.a, it.b, got, expv);
   endtask

   // monitor: compares away from the clock edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() > 0) begin
            item_t it;
            bit bad;
            it = exp_q.pop_front();
            n_checks++;
            bad = 1'b0;
            if (result !== it.res) begin
               fail_line(req_of(it.op), "result", result, it.res, it); bad = 1'b1;
            end
            if (carry_next !== it.cn) begin
               fail_line(req_of(it.op), "carry_next", carry_next, it.cn, it); bad = 1'b1;
            end
            if (zero !== it.z) begin
               fail_line("R9", "zero", zero, it.z, it); bad = 1'b1;
            end
            if (carry_q !== it.cq) begin
               fail_line("R10", "carry_q", carry_q, it.cq, it); bad = 1'b1;
            end
            if (bad) n_fails = n_fails; // counted per field above
         end
      end
   end

   // watchdog
   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog expired before the sequence completed (R10 flow)");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R10: reset holds carry at 0 even with exec and SETC applied
      op = 4'd14; exec = 1'b1; acc_in = 4'h3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_checks++;
      if (carry_q !== 1'b0) begin
         n_fails++;
         $display("FAIL R10 carry_q in reset: got %b expected 0", carry_q);
      end
      exec = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      n_checks++;
      if (carry_q !== 1'b0) begin
         n_fails++;
         $display("FAIL R10 carry_q after reset: got %b expected 0", carry_q);
      end

      // R1: 9+8 overflows, 0+0 gives zero, ADC with carry set
      drive(4'd15, 4'h0, 4'h0, 1'b1);   // CLRC
      drive(4'd0,  4'h9, 4'h8, 1'b1);   // ADD -> 1, carry 1
      drive(4'd1,  4'h7, 4'h8, 1'b1);   // ADC with carry 1 -> 0, carry 1, zero
      drive(4'd0,  4'h0, 4'h0, 1'b1);   // ADD -> 0, carry 0
      // R2: no borrow, borrow, equal operands
      drive(4'd2,  4'h5, 4'h3, 1'b1);   // 2, carry 1
      drive(4'd2,  4'h3, 4'h5, 1'b1);   // E, carry 0
      drive(4'd3,  4'h5, 4'h3, 1'b1);   // SBC carry 0 -> 1, carry 1
      drive(4'd2,  4'h6, 4'h6, 1'b1);   // 0, zero, carry 1
      // R3: decimal adjust cases
      drive(4'd15, 4'h0, 4'h0, 1'b1);
      drive(4'd4,  4'hC, 4'h0, 1'b1);   // 2, carry 1
      drive(4'd4,  4'h5, 4'h0, 1'b1);   // carry set -> B
      drive(4'd15, 4'h0, 4'h0, 1'b1);
      drive(4'd4,  4'h9, 4'h0, 1'b1);   // unchanged
      // R5: wrap cases keep carry
      drive(4'd14, 4'h0, 4'h0, 1'b1);
      drive(4'd8,  4'hF, 4'h0, 1'b1);   // 0, zero, carry stays 1
      drive(4'd9,  4'h0, 4'h0, 1'b1);   // F
      // R6 / R7: rotates
      drive(4'd15, 4'h0, 4'h0, 1'b1);
      drive(4'd10, 4'h8, 4'h0, 1'b1);   // 1, carry 1
      drive(4'd11, 4'h4, 4'h0, 1'b1);   // 9, carry 0
      drive(4'd12, 4'h1, 4'h0, 1'b1);   // 8, carry 1
      drive(4'd13, 4'h2, 4'h0, 1'b1);   // 9, carry 0
      // R4 with carry set and cleared
      drive(4'd14, 4'h0, 4'h0, 1'b1);
      drive(4'd5,  4'hC, 4'hA, 1'b1);
      drive(4'd7,  4'hF, 4'hF, 1'b1);   // zero
      // R10: exec low keeps the flag
      drive(4'd15, 4'h2, 4'h0, 1'b0);
      drive(4'd0,  4'hF, 4'hF, 1'b0);
      drive(4'd6,  4'h1, 4'h2, 1'b1);

      // exhaustive sweep with alternating commit
      for (int o = 0; o < 16; o++) begin
         for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
               drive(4'(o), 4'(a), 4'(b), ((a + b + o) % 3) != 0);
            end
         end
      end

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule